// File: doc/BRIEF.md
# Unsigned Adder-Subtracter with Range Flag

This block adds or subtracts two unsigned operands of a parameterised width (12 bits by default) in pure combinational logic. A single mode input selects the operation: 0 selects addition, 1 selects subtraction. The result is the low bits of the true result, so it wraps modulo 2^WIDTH whenever the true result does not fit.

One status output, the range flag, reports that the true result left the unsigned range. In add mode it means the sum needed one more bit. In subtract mode it means the subtrahend was larger than the minuend, so the difference would be negative. Subtraction reuses the adder: it forms x plus the bitwise inverse of y plus one. The flag is the carry out of the adder in add mode and the inverted carry out in subtract mode.

There is no state and no clock. The two operating modes, ADD and SUB, are the only "states". A change of the mode input is the only "transition", and it takes effect in the same evaluation as any operand change.

Top module: `addsub_range_unit`

## Requirements
- R1: The mode input is decoded as 0 = ADD and 1 = SUB. Operands and result are WIDTH bits wide, with WIDTH = 12 by default.
- R2: In ADD mode, `sum_out` equals (`opnd_a` + `opnd_b`) mod 2^WIDTH.
- R3: In SUB mode, `sum_out` equals (`opnd_a` − `opnd_b`) mod 2^WIDTH. For example, 0 − 1 gives all ones.
- R4: In ADD mode, `range_flag` is 1 exactly when `opnd_a` + `opnd_b` > 2^WIDTH − 1.
- R5: In SUB mode, `range_flag` is 1 exactly when `opnd_b` > `opnd_a`. In that mode it equals the inverse of the carry out of `opnd_a` + ~`opnd_b` + 1.
- R6: In SUB mode with equal operands, `sum_out` is 0 and `range_flag` is 0.
- R7: Both outputs are combinational. They reflect new inputs with no clock edge, and they settle together in the same evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | Unsigned operand x (the minuend in SUB mode) |
| opnd_b | input | WIDTH | Unsigned operand y (the subtrahend in SUB mode) |
| op_sel | input | 1 | Operation select: 0 = ADD, 1 = SUB |
| sum_out | output | WIDTH | Wrapped result |
| range_flag | output | 1 | Overflow in ADD mode, borrow in SUB mode |

## Verification
The bench builds the unit twice: once with the default WIDTH = 12 and once with WIDTH = 4. The narrow copy makes every pairing of operands in both modes checkable, all 512 cases, so the carry chain and the flag selection are covered exhaustively. The 12-bit copy is checked in three ways:
- against a hand-worked vector table;
- against a wide reference computation over every pairing of the edge values (0, 1, 2, mid-range, all ones);
- against random interior operands.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    // Operation encoding on op_sel (R1)
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_mode_e;
endpackage

// File: rtl/addsub_operand_cond.sv
module addsub_operand_cond #(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0]       b_in,
    input  addsub_pkg::op_mode_e   mode,
    output logic [WIDTH-1:0]       b_cond,
    output logic                   carry_seed
);
    import addsub_pkg::*;

    // SUB: feed ~b and a carry-in of 1, giving two's complement negation
    always_comb begin
        unique case (mode)
            OP_ADD: begin
                b_cond     = b_in;
                carry_seed = 1'b0;
            end
            OP_SUB: begin
                b_cond     = ~b_in;
                carry_seed = 1'b1;
            end
            default: begin
                b_cond     = b_in;
                carry_seed = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/addsub_ripple_adder.sv
module addsub_ripple_adder #(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic prop;
        logic gen;
        assign prop         = a[i] ^ b[i];
        assign gen          = a[i] & b[i];
        assign sum[i]       = prop ^ chain[i];
        assign chain[i + 1] = gen | (prop & chain[i]);
    end

    assign cout = chain[WIDTH];
endmodule

// File: rtl/addsub_flag_sel.sv
module addsub_flag_sel (
    input  addsub_pkg::op_mode_e mode,
    input  logic                 carry_out,
    output logic                 flag
);
    import addsub_pkg::*;

    // ADD: carry out means overflow. SUB: a missing carry means borrow.
    always_comb begin
        unique case (mode)
            OP_ADD:  flag = carry_out;
            OP_SUB:  flag = ~carry_out;
            default: flag = carry_out;
        endcase
    end
endmodule

// File: rtl/addsub_range_unit.sv
module addsub_range_unit #(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             op_sel,
    output logic [WIDTH-1:0] sum_out,
    output logic             range_flag
);
    import addsub_pkg::*;

    localparam int WIDE = WIDTH + 1;

    op_mode_e         mode;
    logic [WIDTH-1:0] b_cond;
    logic             carry_seed;
    logic             carry_out;

    assign mode = op_mode_e'(op_sel);

    addsub_operand_cond #(.WIDTH(WIDTH)) u_cond (
        .b_in       (opnd_b),
        .mode       (mode),
        .b_cond     (b_cond),
        .carry_seed (carry_seed)
    );

    addsub_ripple_adder #(.WIDTH(WIDTH)) u_adder (
        .a    (opnd_a),
        .b    (b_cond),
        .cin  (carry_seed),
        .sum  (sum_out),
        .cout (carry_out)
    );

    addsub_flag_sel u_flag (
        .mode      (mode),
        .carry_out (carry_out),
        .flag      (range_flag)
    );

    // Checks against a wide reference, kept independent of the ripple chain
    logic [WIDE-1:0] ref_sum;
    logic [WIDE-1:0] ref_diff;
    assign ref_sum  = {1'b0, opnd_a} + {1'b0, opnd_b};
    assign ref_diff = {1'b0, opnd_a} - {1'b0, opnd_b};

    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, op_sel})) begin
            if (op_sel == 1'b0) begin
                assert_add_result_R2: assert (sum_out == ref_sum[WIDTH-1:0])
                    else $error("R2 sum mismatch");
                assert_add_overflow_R4: assert (range_flag == ref_sum[WIDTH])
                    else $error("R4 overflow flag mismatch");
            end else begin
                assert_sub_result_R3: assert (sum_out == ref_diff[WIDTH-1:0])
                    else $error("R3 difference mismatch");
                assert_sub_borrow_R5: assert (range_flag == (opnd_b > opnd_a))
                    else $error("R5 borrow flag mismatch");
                assert_sub_carry_inv_R5: assert (range_flag == !carry_out)
                    else $error("R5 flag is not inverted carry");
                if (opnd_a == opnd_b) begin
                    assert_sub_equal_zero_R6: assert (sum_out == '0 && !range_flag)
                        else $error("R6 equal operands not zero");
                end
            end
        end
    end
endmodule

// File: tb/addsub_range_unit_tb.sv
module addsub_range_unit_tb_top;
    localparam int W  = 12;
    localparam int NW = 4;
    localparam int NVEC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [W-1:0]  x, y, s;
    logic          mode, flag;
    logic [NW-1:0] nx, ny, ns;
    logic          nmode, nflag;

    addsub_range_unit #(.WIDTH(W)) dut_i (
        .opnd_a(x), .opnd_b(y), .op_sel(mode), .sum_out(s), .range_flag(flag)
    );

    addsub_range_unit #(.WIDTH(NW)) dut_narrow_i (
        .opnd_a(nx), .opnd_b(ny), .op_sel(nmode), .sum_out(ns), .range_flag(nflag)
    );

    // Vector: {req[3:0], mode, x[11:0], y[11:0], s[11:0], flag}
    typedef logic [41:0] vec_t;
    localparam vec_t TABLE [NVEC] = '{
        {4'd2, 1'b0, 12'd0,    12'd0,    12'd0,    1'b0},  // R2 zero
        {4'd4, 1'b0, 12'd4095, 12'd1,    12'd0,    1'b1},  // R4 wrap to 0
        {4'd4, 1'b0, 12'd4095, 12'd4095, 12'd4094, 1'b1},  // R4 max+max
        {4'd4, 1'b0, 12'd2048, 12'd2047, 12'd4095, 1'b0},  // R4 just fits
        {4'd4, 1'b0, 12'd2048, 12'd2048, 12'd0,    1'b1},  // R4 just over
        {4'd2, 1'b0, 12'd100,  12'd200,  12'd300,  1'b0},  // R2 plain
        {4'd3, 1'b1, 12'd0,    12'd1,    12'd4095, 1'b1},  // R3 wrap
        {4'd6, 1'b1, 12'd5,    12'd5,    12'd0,    1'b0},  // R6 equal
        {4'd3, 1'b1, 12'd4095, 12'd0,    12'd4095, 1'b0},  // R3 max-0
        {4'd5, 1'b1, 12'd0,    12'd4095, 12'd1,    1'b1},  // R5 borrow
        {4'd3, 1'b1, 12'd1000, 12'd1,    12'd999,  1'b0},  // R3 plain
        {4'd5, 1'b1, 12'd300,  12'd301,  12'd4095, 1'b1}   // R5 off by one
    };

    task automatic check(input string req, input int got_s, input int got_f,
                         input int exp_s, input int exp_f);
        checks++;
        if (got_s != exp_s || got_f != exp_f) begin
            failures++;
            $display("FAIL %s: got s=%0d flag=%0d, expected s=%0d flag=%0d",
                     req, got_s, got_f, exp_s, exp_f);
        end
    endtask

    // Wide reference model of R2..R5 for a given width
    task automatic ref_model(input int wd, input int m, input int a, input int b,
                             output int rs, output int rf);
        int lim;
        lim = 1 << wd;
        if (m == 0) begin
            rs = (a + b) % lim;
            rf = (a + b >= lim) ? 1 : 0;
        end else begin
            rs = (a - b + lim) % lim;
            rf = (b > a) ? 1 : 0;
        end
    endtask

    task automatic apply_wide(input int m, input int a, input int b, input string req);
        int rs, rf;
        @(posedge clk);
        mode = m[0]; x = a[W-1:0]; y = b[W-1:0];
        #1;
        ref_model(W, m, a, b, rs, rf);
        check(req, int'(s), int'(flag), rs, rf);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: got cycles=%0d expected completion", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    localparam int NEDGE = 7;
    localparam int EDGES [NEDGE] = '{0, 1, 2, 2047, 2048, 4094, 4095};

    initial begin
        x = '0; y = '0; mode = 1'b0;
        nx = '0; ny = '0; nmode = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Initial state: all-zero inputs give zero, no flag (R2, R7)
        #1;
        check("R7 initial", int'(s), int'(flag), 0, 0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = TABLE[i];
            @(posedge clk);
            mode = v[37]; x = v[36:25]; y = v[24:13];
            #1;
            check($sformatf("R%0d table[%0d]", v[41:38], i),
                  int'(s), int'(flag), int'(v[12:1]), int'(v[0]));
        end

        // R7: change only mode within one cycle, outputs follow without an edge
        @(posedge clk);
        mode = 1'b0; x = 12'd10; y = 12'd20;
        #1;
        check("R7 add before toggle", int'(s), int'(flag), 30, 0);
        mode = 1'b1;
        #1;
        check("R7 sub after toggle, no edge", int'(s), int'(flag), 4086, 1);

        // R1/R6: every edge operand pair in both modes
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < NEDGE; i++)
                for (int j = 0; j < NEDGE; j++)
                    apply_wide(m, EDGES[i], EDGES[j],
                               (m == 0) ? "R1 R2 R4 edge add" : "R1 R3 R5 R6 edge sub");

        // R6: equal operands across the range in SUB
        for (int k = 0; k < 4096; k += 273)
            apply_wide(1, k, k, "R6 equal sub");

        // Random interior
        for (int k = 0; k < 3000; k++)
            apply_wide(k % 2, int'($urandom_range(3, 4092)), int'($urandom_range(3, 4092)),
                       (k % 2 == 0) ? "R2 R4 random add" : "R3 R5 random sub");

        // Exhaustive narrow copy (WIDTH=4), R1..R6
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    int rs, rf;
                    @(posedge clk);
                    nmode = m[0]; nx = a[NW-1:0]; ny = b[NW-1:0];
                    #1;
                    ref_model(NW, m, a, b, rs, rf);
                    check((m == 0) ? "R4 narrow add" : "R5 narrow sub",
                          int'(ns), int'(nflag), rs, rf);
                end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule